// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit timer channel. It counts periods of an input count clock, given as a one-cycle enable `cnt_en` on the system clock. A load strobe writes an initial count and a 3-bit operating mode in a single cycle. The mode selects one of six output waveforms:

- interrupt on terminal count
- gate-retriggerable one-shot
- rate pulse
- square wave
- software-started strobe
- gate-started strobe

A rising edge on `gate_in` restarts the count in the modes that can be retriggered. The channel reports three things: the current readable count, the output level, and the configuration as it was loaded.

An initial count of zero stands for the full 65536-clock range. The BCD flag is stored and reported, but counting is always binary. Several channels can be placed side by side. The `CHAN_IDX` parameter sets the gate level the channel assumes at reset.

Top module: `pict_channel`

## Requirements
- R1: After reset the channel is in mode 3 with a count of 65536: `timer_out` = 1, `count_rd` = 0, `mode_o` = 3, `bcd_o` = 0.
- R2: A loaded count of 0 acts as 65536. In mode 0 the output rises after exactly 65536 count clocks, and `count_rd` reads 0 right after the load.
- R3: Mode 0 (code 0). The output is 0 after a load and goes to 1 once the elapsed count clocks reach the count. It then stays 1, and `count_rd` wraps on through 0xFFFF.
- R4: Mode 1 (code 1). The output is 1 while the elapsed count clocks are below the count, and 0 from the moment they reach it.
- R5: Mode 2 (code 2). The output is 1 for exactly one count clock each time the elapsed clocks reach a nonzero multiple of the count. It is not 1 at the load.
- R6: Mode 3 (code 3). In each period of N count clocks, the output is 1 for the first (N+1)/2 clocks and 0 for the rest; this holds for odd N too. `count_rd` = N − ((2·phase) mod N).
- R7: Modes 4 and 5 (codes 4, 5). The output is 1 only while the elapsed count clocks equal the count, so it is a single pulse one count clock wide. No later transition follows.
- R8: A rising `gate_in` edge restarts counting from the loaded count in modes 1, 2, 3 and 5. In modes 0 and 4 it has no effect on the count or on the output.
- R9: `count_rd` reads (count − elapsed) mod 65536 in modes 0, 1, 4 and 5, and count − (elapsed mod count) in mode 2.
- R10: Codes 6 and 7 behave as modes 2 and 3. `mode_o` reports the code exactly as it was loaded.
- R11: A load resets the elapsed count to zero, and `timer_out`/`count_rd` show the new state on the very next clock edge. A load wins over a count-clock enable in the same cycle.
- R12: The BCD flag loaded with the count appears on `bcd_o` and has no effect on counting.
- R13: The gate level assumed at reset is high for `CHAN_IDX` 0 and 1 and low for 2. A gate held high through reset on channel 0 therefore causes no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | One-cycle enable marking a count-clock period |
| gate_in | input | 1 | Gate level; sampled on `clk` to detect edges |
| load_strobe | input | 1 | Loads count, mode and BCD flag this cycle |
| load_count | input | CNT_W | Initial count; 0 means 2^CNT_W |
| load_mode | input | 3 | Operating mode code 0..7 |
| load_bcd | input | 1 | BCD flag, stored only |
| timer_out | output | 1 | Registered channel output level |
| count_rd | output | CNT_W | Registered readable count |
| mode_o | output | 3 | Mode code as loaded |
| bcd_o | output | 1 | BCD flag as loaded |

## Verification
The assertions assume that `cnt_en`, `gate_in` and the load fields are synchronous to `clk`. They also assume the load fields are meaningful only in a cycle where `load_strobe` is high, and that a gate edge is one transition between two sampled levels. The bench changes every input one nanosecond after a rising edge and holds it for whole cycles. Every gate edge is therefore seen by the edge detector exactly once, and loads, ticks and gate edges land in the cycles the expected values were worked out for.

// File: rtl/pict_pkg.sv
package pict_pkg;

  typedef enum logic [2:0] {
    PM_TERM_INT  = 3'd0,
    PM_ONESHOT   = 3'd1,
    PM_RATE      = 3'd2,
    PM_SQUARE    = 3'd3,
    PM_SW_STROBE = 3'd4,
    PM_HW_STROBE = 3'd5
  } pict_mode_e;

  // Codes 6 and 7 alias onto the rate and square modes.
  function automatic pict_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return pict_mode_e'({1'b0, code[1:0]});
    return pict_mode_e'(code);
  endfunction

  // Modes in which a rising gate edge restarts the count.
  function automatic logic gate_restarts(input pict_mode_e m);
    return (m == PM_ONESHOT) || (m == PM_RATE) ||
           (m == PM_SQUARE)  || (m == PM_HW_STROBE);
  endfunction

endpackage

// File: rtl/pict_cfg.sv
module pict_cfg
  import pict_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CHAN_IDX = 0,
  localparam int FW      = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_count,
  input  logic [2:0]       ld_mode,
  input  logic             ld_bcd,
  input  logic             gate_in,
  output logic [FW-1:0]    count_q,
  output logic [FW-1:0]    nxt_count,
  output pict_mode_e       mode_n_q,
  output pict_mode_e       nxt_mode_n,
  output logic [2:0]       mode_raw_q,
  output logic             bcd_q,
  output logic             restart
);

  localparam logic [FW-1:0] FULL_RANGE = FW'(1) << CNT_W;
  localparam logic          GATE_RST   = (CHAN_IDX != 2);

  logic gate_q;

  always_comb begin
    nxt_count  = count_q;
    nxt_mode_n = mode_n_q;
    if (ld) begin
      nxt_count  = (ld_count == '0) ? FULL_RANGE : {1'b0, ld_count};
      nxt_mode_n = fold_mode(ld_mode);
    end
  end

  assign restart = ld | (gate_in & ~gate_q & gate_restarts(mode_n_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= FULL_RANGE;
      mode_n_q   <= PM_SQUARE;
      mode_raw_q <= 3'd3;
      bcd_q      <= 1'b0;
      gate_q     <= GATE_RST;
    end else begin
      count_q  <= nxt_count;
      mode_n_q <= nxt_mode_n;
      gate_q   <= gate_in;
      if (ld) begin
        mode_raw_q <= ld_mode;
        bcd_q      <= ld_bcd;
      end
    end
  end

  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    count_q != '0);

  a_r10_mode_folded: assert property (@(posedge clk) disable iff (rst)
    logic'(mode_n_q[2:1] != 2'b11));

endmodule

// File: rtl/pict_elapsed.sv
module pict_elapsed #(
  parameter int CNT_W = 16,
  localparam int FW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [FW-1:0]    count_q,
  input  logic [CNT_W-1:0] nxt_count_lo,
  output logic [FW-1:0]    d_q,
  output logic [FW-1:0]    ph_q,
  output logic [CNT_W-1:0] dn_q,
  output logic [FW-1:0]    nxt_d,
  output logic [FW-1:0]    nxt_ph,
  output logic [CNT_W-1:0] nxt_dn
);

  // d: elapsed clocks, saturating; ph: position in period; dn: wrapping down count
  always_comb begin
    nxt_d  = d_q;
    nxt_ph = ph_q;
    nxt_dn = dn_q;
    if (restart) begin
      nxt_d  = '0;
      nxt_ph = '0;
      nxt_dn = nxt_count_lo;
    end else if (tick) begin
      nxt_d  = (&d_q) ? d_q : d_q + FW'(1);
      nxt_ph = (ph_q + FW'(1) == count_q) ? '0 : ph_q + FW'(1);
      nxt_dn = dn_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q  <= '0;
      ph_q <= '0;
      dn_q <= '0;
    end else begin
      d_q  <= nxt_d;
      ph_q <= nxt_ph;
      dn_q <= nxt_dn;
    end
  end

  a_r11_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> (d_q == '0) && (ph_q == '0));

  a_r6_phase_in_period: assert property (@(posedge clk) disable iff (rst)
    ph_q < count_q);

  a_r9_down_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> dn_q == $past(dn_q) - CNT_W'(1));

endmodule

// File: rtl/pict_decode.sv
module pict_decode
  import pict_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int FW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  pict_mode_e       mode,
  input  logic [FW-1:0]    count,
  input  logic [FW-1:0]    d,
  input  logic [FW-1:0]    ph,
  input  logic [CNT_W-1:0] dn,
  output logic             out_q,
  output logic [CNT_W-1:0] rd_q
);

  logic [FW:0]       cnt_x, half, two_p, wrap, sq_full;
  logic [FW-1:0]     rate_full;
  logic              out_nxt;
  logic [CNT_W-1:0]  rd_nxt;
  logic              unused_hi;

  always_comb begin
    cnt_x     = {1'b0, count};
    half      = (cnt_x + (FW+1)'(1)) >> 1;
    two_p     = {ph, 1'b0};
    wrap      = (two_p >= cnt_x) ? two_p - cnt_x : two_p;
    sq_full   = cnt_x - wrap;
    rate_full = count - ph;
    unique case (mode)
      PM_TERM_INT: out_nxt = (d >= count);
      PM_ONESHOT:  out_nxt = (d < count);
      PM_RATE:     out_nxt = (ph == '0) && (d != '0);
      PM_SQUARE:   out_nxt = ({1'b0, ph} < half);
      default:     out_nxt = (d == count);
    endcase
    unique case (mode)
      PM_RATE:   rd_nxt = rate_full[CNT_W-1:0];
      PM_SQUARE: rd_nxt = sq_full[CNT_W-1:0];
      default:   rd_nxt = dn;
    endcase
  end

  assign unused_hi = ^{sq_full[FW:CNT_W], rate_full[FW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
      rd_q  <= '0;
    end else begin
      out_q <= out_nxt;
      rd_q  <= rd_nxt;
    end
  end

endmodule

// File: rtl/pict_channel.sv
module pict_channel
  import pict_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int CHAN_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             gate_in,
  input  logic             load_strobe,
  input  logic [CNT_W-1:0] load_count,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  output logic             timer_out,
  output logic [CNT_W-1:0] count_rd,
  output logic [2:0]       mode_o,
  output logic             bcd_o
);

  localparam int FW = CNT_W + 1;

  logic [FW-1:0]    count_q, nxt_count;
  pict_mode_e       mode_n_q, nxt_mode_n;
  logic             restart;
  logic [FW-1:0]    d_q, ph_q, nxt_d, nxt_ph;
  logic [CNT_W-1:0] dn_q, nxt_dn;

  pict_cfg #(.CNT_W(CNT_W), .CHAN_IDX(CHAN_IDX)) cfg_i (
    .clk(clk), .rst(rst), .ld(load_strobe), .ld_count(load_count),
    .ld_mode(load_mode), .ld_bcd(load_bcd), .gate_in(gate_in),
    .count_q(count_q), .nxt_count(nxt_count), .mode_n_q(mode_n_q),
    .nxt_mode_n(nxt_mode_n), .mode_raw_q(mode_o), .bcd_q(bcd_o),
    .restart(restart)
  );

  pict_elapsed #(.CNT_W(CNT_W)) elapsed_i (
    .clk(clk), .rst(rst), .restart(restart), .tick(cnt_en),
    .count_q(count_q), .nxt_count_lo(nxt_count[CNT_W-1:0]),
    .d_q(d_q), .ph_q(ph_q), .dn_q(dn_q),
    .nxt_d(nxt_d), .nxt_ph(nxt_ph), .nxt_dn(nxt_dn)
  );

  pict_decode #(.CNT_W(CNT_W)) decode_i (
    .clk(clk), .rst(rst), .mode(nxt_mode_n), .count(nxt_count),
    .d(nxt_d), .ph(nxt_ph), .dn(nxt_dn),
    .out_q(timer_out), .rd_q(count_rd)
  );

  a_r3_m0_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_n_q == PM_TERM_INT && timer_out && !load_strobe) |=> timer_out);

  a_r7_strobe_once: assert property (@(posedge clk) disable iff (rst)
    ((mode_n_q == PM_SW_STROBE || mode_n_q == PM_HW_STROBE) &&
     timer_out && cnt_en && !restart) |=> !timer_out);

  a_r5_rate_pulse: assert property (@(posedge clk) disable iff (rst)
    (mode_n_q == PM_RATE && count_q > FW'(1) && timer_out && cnt_en &&
     !restart) |=> !timer_out);

  a_r8_gate_ignored_m04: assert property (@(posedge clk) disable iff (rst)
    ((mode_n_q == PM_TERM_INT || mode_n_q == PM_SW_STROBE) &&
     !load_strobe && !cnt_en) |=> $stable(d_q));

endmodule

// File: tb/pict_channel_tb_top.sv
`timescale 1ns/1ps
module pict_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        gate_in = 1'b1;
  logic        load_strobe = 1'b0;
  logic [15:0] load_count = '0;
  logic [2:0]  load_mode = '0;
  logic        load_bcd = 1'b0;
  logic        timer_out;
  logic [15:0] count_rd;
  logic [2:0]  mode_o;
  logic        bcd_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pict_channel dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate_in(gate_in),
    .load_strobe(load_strobe), .load_count(load_count),
    .load_mode(load_mode), .load_bcd(load_bcd),
    .timer_out(timer_out), .count_rd(count_rd),
    .mode_o(mode_o), .bcd_o(bcd_o)
  );

  // One cycle per row: {load, mode, count, tick, exp_out, exp_rd}
  localparam int NROWS = 38;
  localparam logic [37:0] ROWS [NROWS] = '{
    {1'b1, 3'd0, 16'd3, 1'b0, 1'b0, 16'd3},      // R3 load
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd0},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'hFFFF},
    {1'b1, 3'd1, 16'd2, 1'b0, 1'b1, 16'd2},      // R4
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd0},
    {1'b1, 3'd2, 16'd3, 1'b0, 1'b0, 16'd3},      // R5 R9
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd3},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 16'd2},
    {1'b1, 3'd3, 16'd5, 1'b0, 1'b1, 16'd5},      // R6 odd
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd3},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd4},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd5},
    {1'b1, 3'd4, 16'd2, 1'b0, 1'b0, 16'd2},      // R7
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd0},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'hFFFF},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'hFFFE},
    {1'b1, 3'd6, 16'd2, 1'b0, 1'b0, 16'd2},      // R10 code 6
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd1},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd2},
    {1'b1, 3'd7, 16'd4, 1'b0, 1'b1, 16'd4},      // R10 code 7
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd4},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd2},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd4},
    {1'b1, 3'd0, 16'd2, 1'b1, 1'b0, 16'd2},      // R11 load beats tick
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'd1},
    {1'b1, 3'd5, 16'd1, 1'b0, 1'b0, 16'd1},      // R7 mode 5
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b1, 16'd0},
    {1'b0, 3'd0, 16'd0, 1'b1, 1'b0, 16'hFFFF}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic [2:0] m,
                       input logic [15:0] c, input logic tk, input logic b);
    load_strobe = ld; load_mode = m; load_count = c; cnt_en = tk; load_bcd = b;
    @(posedge clk); #1;
    load_strobe = 1'b0; cnt_en = 1'b0; load_bcd = 1'b0;
  endtask

  task automatic ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 cnt_en = 1'b0;
  endtask

  task automatic gate_rise();
    gate_in = 1'b0; @(posedge clk); #1;
    gate_in = 1'b1; @(posedge clk); #1;
    gate_in = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state, gate held high through reset
    repeat (3) @(posedge clk);
    #1;
    check("R1 out", timer_out, 1);
    check("R1 rd", count_rd, 0);
    check("R1 mode", mode_o, 3);
    check("R1 bcd", bcd_o, 0);
    rst = 1'b0;
    ticks(3);  // R13: first tick lands on first edge after reset
    check("R13 rd", count_rd, 16'hFFFA);
    check("R13 out", timer_out, 1);
    gate_in = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      cycle(ROWS[i][37], ROWS[i][36:34], ROWS[i][33:18], ROWS[i][17], 1'b0);
      check($sformatf("R3-R11 row %0d out", i), timer_out, ROWS[i][16]);
      check($sformatf("R3-R11 row %0d rd", i), count_rd, ROWS[i][15:0]);
    end

    // R2 zero count means 65536
    cycle(1'b1, 3'd0, 16'd0, 1'b0, 1'b0);
    check("R2 rd at load", count_rd, 0);
    check("R2 out at load", timer_out, 0);
    ticks(65535);
    check("R2 out before end", timer_out, 0);
    check("R2 rd before end", count_rd, 1);
    ticks(1);
    check("R2 out at end", timer_out, 1);
    check("R2 rd at end", count_rd, 0);

    // R8 gate restart per mode
    cycle(1'b1, 3'd1, 16'd3, 1'b0, 1'b0); ticks(3);
    check("R8 m1 out before", timer_out, 0);
    gate_rise();
    check("R8 m1 out", timer_out, 1);
    check("R8 m1 rd", count_rd, 3);
    cycle(1'b1, 3'd0, 16'd3, 1'b0, 1'b0); ticks(1);
    gate_rise();
    check("R8 m0 rd", count_rd, 2);
    check("R8 m0 out", timer_out, 0);
    cycle(1'b1, 3'd4, 16'd3, 1'b0, 1'b0); ticks(1);
    gate_rise();
    check("R8 m4 rd", count_rd, 2);
    cycle(1'b1, 3'd2, 16'd3, 1'b0, 1'b0); ticks(2);
    gate_rise();
    check("R8 m2 rd", count_rd, 3);
    check("R8 m2 out", timer_out, 0);
    cycle(1'b1, 3'd3, 16'd4, 1'b0, 1'b0); ticks(1);
    gate_rise();
    check("R8 m3 rd", count_rd, 4);
    check("R8 m3 out", timer_out, 1);
    cycle(1'b1, 3'd5, 16'd2, 1'b0, 1'b0); ticks(2);
    check("R8 m5 out before", timer_out, 1);
    gate_rise();
    check("R8 m5 out", timer_out, 0);
    check("R8 m5 rd", count_rd, 2);

    // R12 BCD stored only
    cycle(1'b1, 3'd2, 16'h0010, 1'b0, 1'b1);
    check("R12 bcd", bcd_o, 1);
    check("R12 mode", mode_o, 2);
    ticks(1);
    check("R12 binary rd", count_rd, 16'h000F);

    // R10 raw code reported
    cycle(1'b1, 3'd7, 16'd4, 1'b0, 1'b0);
    check("R10 mode raw", mode_o, 7);
    check("R10 bcd cleared", bcd_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule